// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is one timer channel that drives two pulse-width outputs, `waveA` and `waveB`, from a single up-counter. The counter runs from zero up to a shared period register and then returns to zero. Each output has its own duty register. For each output, a small action field chooses what happens on three events: the counter reaching that output's duty value, the counter wrapping at the period value, and a software trigger. Each action can set, clear, toggle or leave the output alone.

Software programs the channel through a plain write/read register port. A command register starts and stops the counting clock and issues software triggers. A trigger restarts the counter and the prescaler and forces each output to the level that its trigger action selects. This lets an output sit at a fixed low or high level, which covers 0 % and 100 % duty, with no compare action armed. The counting rate is the system clock divided by 2, 8, 32 or 128, or an external slow-tick strobe.

Top module: `dual_wave_timer`

## Requirements
- R1: After reset both outputs are low, every readable address returns zero and the counter does not advance.
- R2: While the clock is enabled, the counter steps once per prescaled tick from 0 up to the period value. On the tick after it equals the period value, it returns to 0.
- R3: The clock-select field, bits [2:0] of the mode register (address 0), gives one tick every 2 (code 0), 8 (code 1), 32 (code 2) or 128 (code 3) clocks. Code 4 takes a tick on each cycle the `slowTick` input is high. Codes 5 to 7 give no ticks.
- R4: The mode register holds three 2-bit action fields for output A: duty event at [4:3], period wrap at [6:5], trigger at [8:7]. Output B uses the same layout at [10:9], [12:11] and [14:13]. Each field is coded 00 none, 01 set, 10 clear, 11 toggle.
- R5: The duty action fires on the tick that brings the counter to the duty value. The period action fires on the tick that wraps it to 0. With set-on-wrap and clear-on-duty, the output is high for duty ticks in every period of period+1 ticks.
- R6: With the opposite actions (clear on wrap, set on duty), the output is low for duty ticks in every period of period+1 ticks.
- R7: When a duty event and a period wrap fall on the same tick, only the duty action applies.
- R8: Writing the command register (address 4) with bit 2 set zeroes the counter and the prescaler on that clock edge. On the same edge it applies each output's trigger action.
- R9: In the command register, bit 0 enables and bit 1 disables counting. Disable wins if both are set. Disable together with trigger stops the counter at 0 and still forces the output levels.
- R10: With no duty or wrap action armed (duty of zero, or duty equal to the period), an output keeps the level its trigger action set for as long as the counter runs.
- R11: Writes to the mode (0), duty A (1), duty B (2) and period (3) registers take effect on the next edge and read back at the same addresses. Address 4 reads the live counter value.
- R12: A toggle action on the wrap event gives a square wave whose high and low phases each last period+1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slowTick | input | 1 | One-cycle strobe used as the tick source for clock select 4 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | CNT_W | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | CNT_W | Read data for `rdAddr`, combinational |
| waveA | output | 1 | Waveform output A |
| waveB | output | 1 | Waveform output B |

## Verification
The assertions assume that `slowTick` is a strobe synchronous to `clk`, and that the counter and the running state change only through the register port. The bench drives every input on the falling clock edge and writes at most one register per cycle. It never rewrites the mode register on the same cycle as a command, so each edge sees one consistent configuration. A behavioural model in the bench follows the counter, the prescaler and both outputs, and is compared with the pins on every cycle. Directed measurements of high time, low time and period cover both polarities, each prescaler choice, the stopped state, fixed levels, toggling and the duty-over-wrap priority.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // one output's action set; packed MSB first: trigger, wrap, duty
  typedef struct packed {
    act_e onTrig;
    act_e onWrap;
    act_e onDuty;
  } out_act_t;

  // control to datapath strobes
  typedef struct packed {
    logic trig;
    logic run;
  } dwt_strobe_t;

  localparam int SEL_W    = 3;
  localparam int ACT_W    = $bits(out_act_t);
  localparam int MODE_W   = SEL_W + 2 * ACT_W;
  localparam int NUM_OUT  = 2;

  localparam int ADR_MODE  = 0;
  localparam int ADR_DUTYA = 1;
  localparam int ADR_DUTYB = 2;
  localparam int ADR_PER   = 3;
  localparam int ADR_CMD   = 4;

  localparam int CMD_EN   = 0;
  localparam int CMD_DIS  = 1;
  localparam int CMD_TRIG = 2;

  function automatic logic applyAct(act_e a, logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/dwt_ctrl.sv
module dwt_ctrl
  import dwt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [CNT_W-1:0]            wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  logic [CNT_W-1:0]            cntVal,
  output logic [CNT_W-1:0]            rdData,
  output dwt_strobe_t                 strb,
  output logic [SEL_W-1:0]            clkSel,
  output out_act_t [NUM_OUT-1:0]      actSel,
  output logic [NUM_OUT-1:0][CNT_W-1:0] duty,
  output logic [CNT_W-1:0]            period
);

  logic [MODE_W-1:0] modeReg;
  logic [CNT_W-1:0]  dutyAReg, dutyBReg, perReg;
  logic              running;
  logic              cmdWr;

  assign cmdWr = wrEn && (wrAddr == ADDR_W'(ADR_CMD));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      dutyAReg <= '0;
      dutyBReg <= '0;
      perReg   <= '0;
      running  <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          ADDR_W'(ADR_MODE):  modeReg  <= wrData[MODE_W-1:0];
          ADDR_W'(ADR_DUTYA): dutyAReg <= wrData;
          ADDR_W'(ADR_DUTYB): dutyBReg <= wrData;
          ADDR_W'(ADR_PER):   perReg   <= wrData;
          default: ;
        endcase
      end
      if (cmdWr) begin
        if (wrData[CMD_DIS])     running <= 1'b0;
        else if (wrData[CMD_EN]) running <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_W'(ADR_MODE):  rdData = CNT_W'(modeReg);
      ADDR_W'(ADR_DUTYA): rdData = dutyAReg;
      ADDR_W'(ADR_DUTYB): rdData = dutyBReg;
      ADDR_W'(ADR_PER):   rdData = perReg;
      ADDR_W'(ADR_CMD):   rdData = cntVal;
      default:            rdData = '0;
    endcase
  end

  assign strb.trig = cmdWr && wrData[CMD_TRIG];
  assign strb.run  = running;
  assign clkSel    = modeReg[SEL_W-1:0];
  assign actSel[0] = out_act_t'(modeReg[SEL_W +: ACT_W]);
  assign actSel[1] = out_act_t'(modeReg[SEL_W+ACT_W +: ACT_W]);
  assign duty[0]   = dutyAReg;
  assign duty[1]   = dutyBReg;
  assign period    = perReg;

  // disable always wins over enable
  p_dis_stops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[CMD_DIS]) |=> !strb.run);

  p_en_starts_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[CMD_EN] && !wrData[CMD_DIS]) |=> strb.run);

endmodule

// File: rtl/dwt_datapath.sv
module dwt_datapath
  import dwt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_DIV = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          slowTick,
  input  dwt_strobe_t                   strb,
  input  logic [SEL_W-1:0]              clkSel,
  input  out_act_t [NUM_OUT-1:0]        actSel,
  input  logic [NUM_OUT-1:0][CNT_W-1:0] duty,
  input  logic [CNT_W-1:0]              period,
  output logic [CNT_W-1:0]              cntVal,
  output logic [NUM_OUT-1:0]            wave
);

  localparam int PRE_W = 2 * NUM_DIV - 1;

  logic [PRE_W-1:0]   pre;
  logic [NUM_DIV-1:0] divTick;
  logic               tick, step, wrap;
  logic [CNT_W-1:0]   cnt, nextCnt;

  // divide by 2^(2g+1): all low bits of the free prescaler at one
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    assign divTick[g] = &pre[2*g:0];
  end

  always_comb begin
    if (clkSel < SEL_W'(NUM_DIV))       tick = divTick[clkSel[$clog2(NUM_DIV)-1:0]];
    else if (clkSel == SEL_W'(NUM_DIV)) tick = slowTick;
    else                                tick = 1'b0;
  end

  assign step    = strb.run && tick && !strb.trig;
  assign wrap    = (cnt == period);
  assign nextCnt = wrap ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= strb.trig ? '0 : pre + 1'b1;
      if (strb.trig)  cnt <= '0;
      else if (step)  cnt <= nextCnt;
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic hit;
    assign hit = (nextCnt == duty[o]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           wave[o] <= 1'b0;
      else if (strb.trig)  wave[o] <= applyAct(actSel[o].onTrig, wave[o]);
      else if (step) begin
        if (hit)           wave[o] <= applyAct(actSel[o].onDuty, wave[o]);
        else if (wrap)     wave[o] <= applyAct(actSel[o].onWrap, wave[o]);
      end
    end
  end

  assign cntVal = cnt;

  p_trig_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.trig |=> (cntVal == '0));

  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.trig) |=> $stable(cntVal));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (step && cnt == period) |=> (cntVal == '0));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!step && !strb.trig) |=> $stable(wave));

endmodule

// File: rtl/dual_wave_timer.sv
module dual_wave_timer
  import dwt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 3,
  parameter int NUM_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              waveA,
  output logic              waveB
);

  dwt_strobe_t                   strb;
  logic [SEL_W-1:0]              clkSel;
  out_act_t [NUM_OUT-1:0]        actSel;
  logic [NUM_OUT-1:0][CNT_W-1:0] duty;
  logic [CNT_W-1:0]              period, cntVal;
  logic [NUM_OUT-1:0]            wave;

  dwt_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .cntVal(cntVal), .rdData(rdData), .strb(strb),
    .clkSel(clkSel), .actSel(actSel), .duty(duty), .period(period)
  );

  dwt_datapath #(.CNT_W(CNT_W), .NUM_DIV(NUM_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .strb(strb),
    .clkSel(clkSel), .actSel(actSel), .duty(duty), .period(period),
    .cntVal(cntVal), .wave(wave)
  );

  assign waveA = wave[0];
  assign waveB = wave[1];

endmodule

// File: tb/dual_wave_timer_tb.sv
module dual_wave_timer_tb;

  localparam int CW = 16;
  localparam int AW = 3;
  localparam int MASK = 32'hFFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [CW-1:0] rdData;
  logic waveA, waveB;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int slowCnt = 0;

  always #10 clk = ~clk;

  dual_wave_timer #(.CNT_W(CW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .waveA(waveA), .waveB(waveB)
  );

  // slow tick strobe: one cycle in five
  always @(negedge clk) begin
    slowCnt = (slowCnt + 1) % 5;
    slowTick <= (slowCnt == 0);
  end

  // ---------------- behavioural reference ----------------
  int mMode, mDa, mDb, mPer, mCnt, mPre;
  bit mRun, mA, mB;

  function automatic bit doAct(int code, bit cur);
    case (code & 3)
      1: return 1'b1;
      2: return 1'b0;
      3: return !cur;
      default: return cur;
    endcase
  endfunction

  function automatic bit tickOf(int sel, int pre, bit slow);
    if (sel <= 3) return ((pre + 1) % (2 << (2 * sel))) == 0;
    if (sel == 4) return slow;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mDa = 0; mDb = 0; mPer = 0; mCnt = 0; mPre = 0;
      mRun = 0; mA = 0; mB = 0;
    end else begin
      bit trig, adv, wr;
      int nxt;
      trig = wrEn && wrAddr == 4 && wrData[2];
      adv  = mRun && !trig && tickOf(mMode & 7, mPre, slowTick);
      wr   = (mCnt == mPer);
      nxt  = wr ? 0 : ((mCnt + 1) & MASK);
      if (trig) begin
        mA = doAct(mMode >> 7, mA);
        mB = doAct(mMode >> 13, mB);
        mCnt = 0;
      end else if (adv) begin
        if (nxt == mDa) mA = doAct(mMode >> 3, mA);
        else if (wr)    mA = doAct(mMode >> 5, mA);
        if (nxt == mDb) mB = doAct(mMode >> 9, mB);
        else if (wr)    mB = doAct(mMode >> 11, mB);
        mCnt = nxt;
      end
      mPre = trig ? 0 : (mPre + 1) % 128;
      if (wrEn) begin
        case (wrAddr)
          0: mMode = wrData & 32'h7FFF;
          1: mDa = wrData;
          2: mDb = wrData;
          3: mPer = wrData;
          4: if (wrData[1]) mRun = 0; else if (wrData[0]) mRun = 1;
          default: ;
        endcase
      end
    end
  end

  // compare pins with the reference on every cycle (R4 R5 R6 R7 R12)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (waveA !== mA || waveB !== mB) begin
        fails++;
        $display("FAIL R4/R5 per-cycle: actual A=%0b B=%0b expected A=%0b B=%0b at %0t",
                 waveA, waveB, mA, mB, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    wrEn = 1'b1; wrAddr = AW'(addr); wrData = CW'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int addr, output int val);
    rdAddr = AW'(addr);
    #1 val = int'(rdData);
  endtask

  function automatic int mk(int sel, int ad, int ap, int at, int bd, int bp, int bt);
    return sel | (ad << 3) | (ap << 5) | (at << 7) | (bd << 9) | (bp << 11) | (bt << 13);
  endfunction

  // measure cycles at level lvl and total period, starting at entry to lvl
  task automatic measure(bit useB, bit lvl, int expLvl, int expPer, string tag);
    int t, nLvl, nOther;
    t = 0;
    while (((useB ? waveB : waveA) == lvl) && t < 3000) begin @(negedge clk); t++; end
    while (((useB ? waveB : waveA) != lvl) && t < 3000) begin @(negedge clk); t++; end
    nLvl = 0; nOther = 0;
    while (((useB ? waveB : waveA) == lvl) && t < 3000) begin @(negedge clk); t++; nLvl++; end
    while (((useB ? waveB : waveA) != lvl) && t < 3000) begin @(negedge clk); t++; nOther++; end
    chk(nLvl == expLvl, {tag, " level time"}, nLvl, expLvl);
    chk(nLvl + nOther == expPer, {tag, " period"}, nLvl + nOther, expPer);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int v, v2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(waveA == 0 && waveB == 0, "R1 outputs low", {waveA, waveB}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk(v == 0, "R1 register zero", v, 0);
    end
    repeat (10) @(negedge clk);
    rd(4, v);
    chk(v == 0, "R1 counter stopped", v, 0);

    // R11: write and read back
    wr(3, 9); wr(1, 3); wr(2, 4);
    wr(0, mk(0, 2, 1, 1, 1, 2, 2));
    rd(0, v); chk(v == mk(0, 2, 1, 1, 1, 2, 2), "R11 mode readback", v, mk(0, 2, 1, 1, 1, 2, 2));
    rd(1, v); chk(v == 3, "R11 dutyA readback", v, 3);
    rd(2, v); chk(v == 4, "R11 dutyB readback", v, 4);
    rd(3, v); chk(v == 9, "R11 period readback", v, 9);

    // R5/R6: both polarities, divide by 2
    wr(4, 5);
    measure(0, 1, 6, 20, "R5 normal A");
    measure(1, 0, 8, 20, "R6 inverted B");

    // R2: counter never passes the period
    for (int i = 0; i < 25; i++) begin
      rd(4, v);
      chk(v <= 9, "R2 counter bound", v, 9);
      @(negedge clk);
    end

    // R3: divide by 8 and slow tick
    wr(0, mk(1, 2, 1, 1, 1, 2, 2)); wr(4, 5);
    measure(0, 1, 24, 80, "R3 div8");
    wr(0, mk(4, 2, 1, 1, 1, 2, 2)); wr(4, 5);
    measure(0, 1, 15, 50, "R3 slow tick");
    wr(0, mk(5, 2, 1, 1, 1, 2, 2)); wr(4, 5);
    repeat (40) @(negedge clk);
    rd(4, v);
    chk(v == 0, "R3 unused select no ticks", v, 0);

    // R8: trigger forces level and zeroes counter at once
    wr(0, mk(0, 2, 1, 2, 1, 2, 1)); wr(4, 1);
    repeat (7) @(negedge clk);
    wr(4, 4);
    rd(4, v);
    chk(v == 0, "R8 counter zeroed", v, 0);
    chk(waveA == 0 && waveB == 1, "R8 forced levels", {waveA, waveB}, 1);

    // R9: disable with trigger stops, still forces levels
    wr(0, mk(0, 2, 1, 1, 1, 2, 2)); wr(4, 6);
    chk(waveA == 1 && waveB == 0, "R9 dis+trig levels", {waveA, waveB}, 2);
    repeat (30) @(negedge clk);
    rd(4, v);
    chk(v == 0, "R9 stopped", v, 0);
    wr(4, 3);
    repeat (20) @(negedge clk);
    rd(4, v);
    chk(v == 0, "R9 disable wins over enable", v, 0);

    // R10: static levels with no compare actions armed
    wr(1, 0); wr(2, 9);
    wr(0, mk(0, 0, 0, 1, 0, 0, 2)); wr(4, 5);
    repeat (60) @(negedge clk);
    rd(4, v); repeat (3) @(negedge clk); rd(4, v2);
    chk(v != v2, "R10 counter running", v2, v);
    chk(waveA == 1, "R10 fixed high", waveA, 1);
    chk(waveB == 0, "R10 fixed low", waveB, 0);

    // R12: toggle on wrap
    wr(1, 3);
    wr(0, mk(0, 0, 3, 2, 0, 0, 2)); wr(4, 5);
    measure(0, 1, 20, 40, "R12 toggle");

    // R7: duty 0 clear beats wrap set
    wr(1, 0);
    wr(0, mk(0, 2, 1, 1, 0, 0, 2)); wr(4, 5);
    chk(waveA == 1, "R7 trigger set", waveA, 1);
    repeat (45) @(negedge clk);
    chk(waveA == 0, "R7 duty wins over wrap", waveA, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule